// File: doc/BRIEF.md
# Mixed-Class Reset Register Bank

This block is a small memory-mapped bank of 32-bit control words. It drives a set of reset lines for CPU cores, cache-flush requests and peripherals. Each line belongs to one of five behaviour classes.

Two classes belong to the CPU words:

- **Self-timed core reset.** The line pulses for a fixed time, then posts a completion flag.
- **Software-held core reset.** The line stays asserted until software releases it, and completion is flagged at that release.

Both CPU words also carry a self-timed flush request that has no completion flag. In the CPU words every control or flag bit at position n in the low half-word is only acted on when bit n+16 of the same write is one.

The other two words serve peripherals:

- **Peripheral pulse word.** Each bit launches an independent self-timed pulse and later posts its own completion flag high in the word.
- **Peripheral hold word.** It holds a vector of lines that software drives directly. These bits are active low, except one line that is active high.

Software starts a reset by writing the word and later polls the flag. Completion flags are cleared by writing one to them. Every reset output of the block is active high (1 = target held in reset).

Top module: `rstc_top`

## Requirements
- R1: After power-on reset every reset output is 0, the two CPU words and the peripheral pulse word read 0, and the peripheral hold word (offset 0x0C) reads 0x7F.
- R2: In the CPU words (offset 0x00 = self-timed core, 0x04 = held core), a write to bit n of [15:0] has no effect unless bit n+16 of the same write is 1. This covers control bits and the completion-flag clear alike.
- R3: Writing bit 0 with bit 16 to offset 0x00 raises the self-timed core line for exactly PULSE_LEN (default 8) cycles. While the line is high, bit 0 of that word reads 1.
- R4: The completion flag of the self-timed core (bit 12 of 0x00) is 0 while the pulse runs and reads 1 from the first cycle in which the line is low again.
- R5: Writing bit 4 with bit 20 to either CPU word raises that word's flush line for PULSE_LEN cycles, and no completion flag is set by it.
- R6: At offset 0x04, bit 0 written with bit 16 sets or releases the held core line. Releasing an asserted line sets bit 12 in the same cycle that the line drops.
- R7: At offset 0x08, writing 1 to bit i (i = 0..2) starts an independent PULSE_LEN-cycle pulse on peripheral line i. No write enable is needed, a 0 bit has no effect, and on completion flag bit 28+i is set.
- R8: Completion flags are cleared only by writing 1 to their own bit (with bit n+16 in the CPU words). Writing 0 to a flag leaves it unchanged, and clearing one flag leaves the others untouched.
- R9: The bits of offset 0x0C hold their written value. Peripheral hold lines 0..6 are asserted while their bit is 0, and line 7 is asserted while its bit is 1.
- R10: In the CPU words bits 31:16 always read 0. Addresses other than 0x00, 0x04, 0x08 and 0x0C read 0, and writes to them change no state.
- R11: A write to a self-timed line while its pulse is running neither restarts nor cuts short that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| cpuAResetO | output | 1 | Self-timed core reset line |
| cpuAFlushO | output | 1 | Flush request line of word 0x00 |
| cpuBResetO | output | 1 | Software-held core reset line |
| cpuBFlushO | output | 1 | Flush request line of word 0x04 |
| hwResetO | output | N_HW | Peripheral pulse reset lines |
| swResetO | output | N_SW | Peripheral hold reset lines, active high |

## Verification
A wrong pulse counter would show on the reset pins as a line that stays high too long or too short. Within PULSE_LEN + 1 cycles the completion flag would then be seen by a read early, late or never. A broken write-enable guard or flag-clear path shows at the very next read of the word, as a control or flag bit that moved without its enable. A wrong polarity mapping in the hold word is visible on swResetO in the cycle after the write.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int DATA_W    = 32;
  localparam int WE_SHIFT  = 16;
  localparam int CPU_RST_B = 0;
  localparam int CPU_FLU_B = 4;
  localparam int CPU_DON_B = 12;
  localparam int HW_DON_LSB = 28;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CPUA,
    SEL_CPUB,
    SEL_HW,
    SEL_SW
  } regSel_e;

  typedef struct packed {
    logic              wrCpuA;
    logic              wrCpuB;
    logic              wrHw;
    logic              wrSw;
    regSel_e           rdSel;
    logic [DATA_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
  import rstc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int OFS_CPUA = 'h00,
  parameter int OFS_CPUB = 'h04,
  parameter int OFS_HW   = 'h08,
  parameter int OFS_SW   = 'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb
);
  regSel_e hit;

  always_comb begin
    if (busAddr == ADDR_W'(OFS_CPUA))      hit = SEL_CPUA;
    else if (busAddr == ADDR_W'(OFS_CPUB)) hit = SEL_CPUB;
    else if (busAddr == ADDR_W'(OFS_HW))   hit = SEL_HW;
    else if (busAddr == ADDR_W'(OFS_SW))   hit = SEL_SW;
    else                                   hit = SEL_NONE;
  end

  always_comb begin
    strb.rdSel  = hit;
    strb.wdata  = busWdata;
    strb.wrCpuA = busSel && busWe && (hit == SEL_CPUA);
    strb.wrCpuB = busSel && busWe && (hit == SEL_CPUB);
    strb.wrHw   = busSel && busWe && (hit == SEL_HW);
    strb.wrSw   = busSel && busWe && (hit == SEL_SW);
  end

  // R10: at most one word is written per access
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCpuA, strb.wrCpuB, strb.wrHw, strb.wrSw}));
endmodule

// File: rtl/rstc_pulse.sv
module rstc_pulse #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic startI,
  output logic activeO,
  output logic endO
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cnt <= '0;
    else if (cnt != '0)         cnt <= cnt - 1'b1;
    else if (startI)            cnt <= CW'(LEN);
  end

  assign activeO = (cnt != '0);
  assign endO    = (cnt == CW'(1));

  // R11: a running pulse is not cut short by any input
  a_r11_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (activeO && !endO) |=> activeO);
  // R3: a pulse only begins from idle on a start request
  a_r3_start_only: assert property (@(posedge clk) disable iff (!rstN)
    (!activeO && !startI) |=> !activeO);
endmodule

// File: rtl/rstc_dp.sv
module rstc_dp
  import rstc_pkg::*;
#(
  parameter int PULSE_LEN   = 8,
  parameter int N_HW        = 3,
  parameter int N_SW        = 8,
  parameter int SW_HIGH_IDX = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] rdata,
  output logic              cpuAResetO,
  output logic              cpuAFlushO,
  output logic              cpuBResetO,
  output logic              cpuBFlushO,
  output logic [N_HW-1:0]   hwResetO,
  output logic [N_SW-1:0]   swResetO
);
  localparam logic [N_SW-1:0] SW_INIT = {N_SW{1'b1}} & ~(N_SW'(1) << SW_HIGH_IDX);

  logic [DATA_W-1:0] wd;
  assign wd = strb.wdata;

  // guarded bit: acted on only with its enable in the upper half
  function automatic logic gbit(input logic [DATA_W-1:0] d, input int n);
    return d[n] && d[n + WE_SHIFT];
  endfunction

  // ---------------- self-timed core word ----------------
  logic cpuAEnd, cpuADone, flushAEnd, flushBEnd;

  rstc_pulse #(.LEN(PULSE_LEN)) u_cpuA (
    .clk(clk), .rstN(rstN),
    .startI(strb.wrCpuA && gbit(wd, CPU_RST_B)),
    .activeO(cpuAResetO), .endO(cpuAEnd));

  rstc_pulse #(.LEN(PULSE_LEN)) u_flushA (
    .clk(clk), .rstN(rstN),
    .startI(strb.wrCpuA && gbit(wd, CPU_FLU_B)),
    .activeO(cpuAFlushO), .endO(flushAEnd));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   cpuADone <= 1'b0;
    else if (cpuAEnd)                            cpuADone <= 1'b1;
    else if (strb.wrCpuA && gbit(wd, CPU_DON_B)) cpuADone <= 1'b0;
  end

  // ---------------- software-held core word ----------------
  logic cpuBRst, cpuBDone;
  logic cpuBRelease;

  assign cpuBRelease = strb.wrCpuB && wd[CPU_RST_B + WE_SHIFT] && !wd[CPU_RST_B] && cpuBRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        cpuBRst <= 1'b0;
    else if (strb.wrCpuB && wd[CPU_RST_B + WE_SHIFT]) cpuBRst <= wd[CPU_RST_B];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   cpuBDone <= 1'b0;
    else if (cpuBRelease)                        cpuBDone <= 1'b1;
    else if (strb.wrCpuB && gbit(wd, CPU_DON_B)) cpuBDone <= 1'b0;
  end

  assign cpuBResetO = cpuBRst;

  rstc_pulse #(.LEN(PULSE_LEN)) u_flushB (
    .clk(clk), .rstN(rstN),
    .startI(strb.wrCpuB && gbit(wd, CPU_FLU_B)),
    .activeO(cpuBFlushO), .endO(flushBEnd));

  // ---------------- peripheral pulse word ----------------
  logic [N_HW-1:0] hwEnd, hwDone;

  for (genvar i = 0; i < N_HW; i++) begin : g_hw
    rstc_pulse #(.LEN(PULSE_LEN)) u_hw (
      .clk(clk), .rstN(rstN),
      .startI(strb.wrHw && wd[i]),
      .activeO(hwResetO[i]), .endO(hwEnd[i]));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  hwDone[i] <= 1'b0;
      else if (hwEnd[i])                          hwDone[i] <= 1'b1;
      else if (strb.wrHw && wd[HW_DON_LSB + i])   hwDone[i] <= 1'b0;
    end

    // R7: a flag rises only as its own line drops
    a_r7_hw_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
      $rose(hwDone[i]) |-> $fell(hwResetO[i]));
  end

  // ---------------- peripheral hold word ----------------
  logic [N_SW-1:0] swBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          swBits <= SW_INIT;
    else if (strb.wrSw) swBits <= wd[N_SW-1:0];
  end

  for (genvar j = 0; j < N_SW; j++) begin : g_sw
    if (j == SW_HIGH_IDX) begin : g_hi
      assign swResetO[j] = swBits[j];
    end else begin : g_lo
      assign swResetO[j] = !swBits[j];
    end
  end

  // ---------------- readback ----------------
  always_comb begin
    rdata = '0;
    case (strb.rdSel)
      SEL_CPUA: begin
        rdata[CPU_RST_B] = cpuAResetO;
        rdata[CPU_FLU_B] = cpuAFlushO;
        rdata[CPU_DON_B] = cpuADone;
      end
      SEL_CPUB: begin
        rdata[CPU_RST_B] = cpuBRst;
        rdata[CPU_FLU_B] = cpuBFlushO;
        rdata[CPU_DON_B] = cpuBDone;
      end
      SEL_HW: begin
        rdata[N_HW-1:0]                = hwResetO;
        rdata[HW_DON_LSB +: N_HW]      = hwDone;
      end
      SEL_SW:  rdata[N_SW-1:0] = swBits;
      default: rdata = '0;
    endcase
  end

  logic unusedEnds;
  assign unusedEnds = flushAEnd ^ flushBEnd;

  // R4: core completion flag appears only as the core line drops
  a_r4_cpua_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuADone) |-> $fell(cpuAResetO));
  // R2: held core line ignores writes lacking its enable bit
  a_r2_cpub_guard: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCpuB && !wd[CPU_RST_B + WE_SHIFT]) |=> $stable(cpuBRst));
  // R6: held core flag rises only on release of the line
  a_r6_cpub_done_on_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuBDone) |-> $fell(cpuBRst));
  // R9: hold word changes only when written
  a_r9_sw_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrSw |=> $stable(swBits));
  // R5: flush activity never disturbs the core flag
  a_r5_flush_no_done: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuAEnd && !strb.wrCpuA) |=> $stable(cpuADone));
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PULSE_LEN   = 8,
  parameter int N_HW        = 3,
  parameter int N_SW        = 8,
  parameter int SW_HIGH_IDX = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              cpuAResetO,
  output logic              cpuAFlushO,
  output logic              cpuBResetO,
  output logic              cpuBFlushO,
  output logic [N_HW-1:0]   hwResetO,
  output logic [N_SW-1:0]   swResetO
);
  strobe_t strb;

  rstc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .strb(strb));

  rstc_dp #(
    .PULSE_LEN(PULSE_LEN), .N_HW(N_HW), .N_SW(N_SW), .SW_HIGH_IDX(SW_HIGH_IDX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdata(busRdata),
    .cpuAResetO(cpuAResetO), .cpuAFlushO(cpuAFlushO),
    .cpuBResetO(cpuBResetO), .cpuBFlushO(cpuBFlushO),
    .hwResetO(hwResetO), .swResetO(swResetO));
endmodule

// File: tb/sim_rstc_top.sv
module sim_rstc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWe;
  logic [7:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  logic        cpuAResetO, cpuAFlushO, cpuBResetO, cpuBFlushO;
  logic [2:0]  hwResetO;
  logic [7:0]  swResetO;

  int total = 0;
  int failed = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rstc_top u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cpuAResetO(cpuAResetO),
    .cpuAFlushO(cpuAFlushO), .cpuBResetO(cpuBResetO), .cpuBFlushO(cpuBFlushO),
    .hwResetO(hwResetO), .swResetO(swResetO));

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] d;
    logic [7:0]  ra;
    logic [31:0] e;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 32'h0000_0001, 8'h04, 32'h0000_0000, 8'd2},  // R2 no enable
    '{8'h04, 32'h0001_0001, 8'h04, 32'h0000_0001, 8'd6},  // R6 assert held core
    '{8'h0C, 32'h0000_00F0, 8'h0C, 32'h0000_00F0, 8'd9},  // R9
    '{8'h0C, 32'h0000_007F, 8'h0C, 32'h0000_007F, 8'd9},  // R9
    '{8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000, 8'd10}, // R10 unmapped
    '{8'h04, 32'h0000_0000, 8'h04, 32'h0000_0001, 8'd2}   // R2 release lacks enable
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1;
    v = busRdata;
    busSel = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n, m;
    rstN = 1'b0; busSel = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {20'd0, cpuAResetO, cpuAFlushO, cpuBResetO, cpuBFlushO, hwResetO, swResetO}, 32'd0);
    rd(8'h00, v); chk("R1 word00", v, 32'h0);
    rd(8'h04, v); chk("R1 word04", v, 32'h0);
    rd(8'h08, v); chk("R1 word08", v, 32'h0);
    rd(8'h0C, v); chk("R1 word0C", v, 32'h7F);

    // table walk
    for (int k = 0; k < NV; k++) begin
      wr(VECS[k].a, VECS[k].d);
      rd(VECS[k].ra, v);
      chk($sformatf("R%0d vector %0d", VECS[k].tag, k), v, VECS[k].e);
    end
    chk("R6 held line asserted", {31'd0, cpuBResetO}, 32'd1);

    // R6 release sets flag in the same cycle
    wr(8'h04, 32'h0001_0000);
    chk("R6 line released", {31'd0, cpuBResetO}, 32'd0);
    rd(8'h04, v); chk("R6 flag on release", v, 32'h0000_1000);
    wr(8'h04, 32'h0000_1000);
    rd(8'h04, v); chk("R2 flag clear lacks enable", v, 32'h0000_1000);
    wr(8'h04, 32'h1000_1000);
    rd(8'h04, v); chk("R8 flag cleared", v, 32'h0);

    // R9 polarity
    wr(8'h0C, 32'h0000_00F0);
    chk("R9 mixed polarity", {24'd0, swResetO}, 32'h8F);
    wr(8'h0C, 32'h0000_007F);
    chk("R9 all released", {24'd0, swResetO}, 32'h00);

    // R2 core start lacks enable
    wr(8'h00, 32'h0000_0001);
    @(negedge clk);
    chk("R2 no core pulse", {31'd0, cpuAResetO}, 32'd0);

    // R3 / R4 self-timed core
    wr(8'h00, 32'h0001_0001);
    rd(8'h00, v); chk("R3 bit reads while running", v, 32'h1);
    n = 0;
    for (int j = 0; j < 12; j++) begin
      if (cpuAResetO) n++;
      if (j == 7) begin rd(8'h00, v); chk("R4 flag clear while running", v[12], 1'b0); end
      if (j == 8) begin rd(8'h00, v); chk("R4 flag at drop", v, 32'h0000_1000); end
      @(negedge clk);
    end
    chk("R3 pulse length", n, 8);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, v); chk("R8 zero leaves flag", v, 32'h0000_1000);
    wr(8'h00, 32'h1000_1000);
    rd(8'h00, v); chk("R8 core flag cleared", v, 32'h0);

    // R5 flush on both words
    wr(8'h00, 32'h0010_0010);
    n = 0;
    for (int j = 0; j < 12; j++) begin
      if (cpuAFlushO) n++;
      @(negedge clk);
    end
    chk("R5 flush A length", n, 8);
    rd(8'h00, v); chk("R5 no flag from flush", v, 32'h0);
    wr(8'h04, 32'h0010_0010);
    n = 0;
    for (int j = 0; j < 12; j++) begin
      if (cpuBFlushO) n++;
      @(negedge clk);
    end
    chk("R5 flush B length", n, 8);
    rd(8'h04, v); chk("R5 no flag word04", v, 32'h0);

    // R7 peripheral pulses on lines 0 and 2
    wr(8'h08, 32'h0000_0005);
    n = 0; m = 0;
    for (int j = 0; j < 12; j++) begin
      if (hwResetO[0]) n++;
      if (hwResetO[1]) m++;
      @(negedge clk);
    end
    chk("R7 line0 length", n, 8);
    chk("R7 line1 untouched", m, 0);
    rd(8'h08, v); chk("R7 flags", v, 32'h5000_0000);
    wr(8'h08, 32'h4000_0000);
    rd(8'h08, v); chk("R8 single flag clear", v, 32'h1000_0000);

    // R11 writes during a running pulse
    wr(8'h08, 32'h0000_0002);
    n = 0;
    for (int j = 0; j < 3; j++) begin
      if (hwResetO[1]) n++;
      @(negedge clk);
    end
    if (hwResetO[1]) n++;
    wr(8'h08, 32'h0000_0002);
    if (hwResetO[1]) n++;
    wr(8'h08, 32'h0000_0000);
    for (int j = 0; j < 10; j++) begin
      if (hwResetO[1]) n++;
      @(negedge clk);
    end
    chk("R11 no restart or abort", n, 8);
    rd(8'h08, v); chk("R7 line1 flag", v, 32'h3000_0000);

    // R10 upper half of CPU words reads zero
    wr(8'h04, 32'hFFFE_FFFE);
    rd(8'h04, v); chk("R10 upper half zero", v[31:16], 16'h0);

    finish_run();
  end
endmodule